// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Port

This block is the read side of a mask-style read-only memory. One array of 2^AW words, each two bytes wide, is served in one of two shapes: as a full-width word memory, or as a byte memory with one extra address bit. A mode input selects the shape. In byte mode a separate low-order address input picks which half of the addressed word is placed on the low data lane, and the upper lane is left undriven.

The port decodes an active-low chip enable and two output enables. The active level of each output enable is fixed by parameter. The second enable can also be built as "ignore", so that it never blocks the bus. The bus is modelled as a data vector plus a per-bit drive-enable vector. The analog access times are modelled as clock-cycle latencies: a longer one for address and chip-enable access, and a shorter one for output-enable access. A valid flag rises only when both latencies have elapsed. The array contents are computed by a hash of the word address, so every read can be predicted and no initialisation file is needed.

Top module: `bwrom_port`

## Requirements
- R1: With `word_mode`=1 and the port enabled, once valid, `dout` carries the full word at `addr` and all bits of `dout_oe` are 1.
- R2: With `word_mode`=0, once valid, `dout[7:0]` holds bits 7:0 of the word at `addr` when `a_lsb`=0, and bits 15:8 when `a_lsb`=1. `dout[15:8]` is 0 and `dout_oe` is 16'h00FF.
- R3: One edge after `ce_n` is sampled high, `dout_oe` is all zero, `dvalid` is 0 and `standby` is 1, whatever the other inputs are. The same state holds during reset.
- R4: With `ce_n` low but either output enable inactive, one edge later `dout_oe` is all zero, `dvalid` is 0 and `standby` is 0.
- R5: `oe_a` is active at the level set by `OE_A_POL`. `oe_b` is active at the level set by `OE_B_POL`, or it has no effect when `OE_B_POL` selects ignore. The polarity codes are: 0 = active low, 1 = active high, 2 = ignore.
- R6: If a new value of {`word_mode`, `addr`, `a_lsb` in byte mode}, or chip enable, is first sampled at edge k, then `dvalid` is 0 after edges k to k+ACC_LAT-1 and is 1 after edge k+ACC_LAT, provided the output enables are also settled.
- R7: If the output enables first become active at edge k while the address is settled, the drive enables turn on after edge k, and `dvalid` rises after edge k+OE_LAT.
- R8: When the address key changes while `dvalid` is 1, `dout` keeps its previous value for one more cycle with `dvalid` at 0. After that it reads 0 until it is valid again.
- R9: The word at address a is bits 15:0 of (m ^ (m >> 16) ^ SEED), where m = a * 32'h9E3779B1 in 32-bit arithmetic.
- R10: In word mode, toggling `a_lsb` neither lowers `dvalid` nor changes `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| a_lsb | input | 1 | Byte select, used in byte mode only |
| word_mode | input | 1 | 1 = word organisation, 0 = byte organisation |
| ce_n | input | 1 | Chip enable, active low |
| oe_a | input | 1 | First output enable, polarity set by OE_A_POL |
| oe_b | input | 1 | Second output enable, polarity set by OE_B_POL or ignored |
| dout | output | 2*BW | Read data |
| dout_oe | output | 2*BW | Per-bit drive enable of the modelled three-state bus |
| dvalid | output | 1 | Data meets all access latencies |
| standby | output | 1 | Chip deselected |

## Verification
The main instance is built with ACC_LAT=3 and OE_LAT=1, with `oe_a` active low and `oe_b` active high. With these values the latency edges, the one-cycle hold window and the gap before new data all fall a few cycles apart, so each can be sampled on its own. A second instance uses `oe_a` active high and `oe_b` set to ignore. This lets the bench show that both polarity settings and the ignore setting act at the pins. Random reads over the full 17-bit address range in both modes exercise the content hash and the byte steering.

// File: rtl/bwrom_pkg.sv
package bwrom_pkg;

   typedef enum logic [1:0] {
      OE_ACT_LOW  = 2'd0,
      OE_ACT_HIGH = 2'd1,
      OE_IGNORE   = 2'd2
   } oe_pol_e;

   // content hash: word at address a
   function automatic logic [31:0] rom_hash(input logic [31:0] a, input logic [31:0] seed);
      logic [31:0] m;
      m = a * 32'h9E3779B1;
      return m ^ (m >> 16) ^ seed;
   endfunction

endpackage

// File: rtl/bwrom_en_dec.sv
module bwrom_en_dec
   import bwrom_pkg::*;
#(
   parameter oe_pol_e POL_A = OE_ACT_LOW,
   parameter oe_pol_e POL_B = OE_ACT_HIGH
) (
   input  logic ce_n,
   input  logic oe_a,
   input  logic oe_b,
   output logic chip_on,
   output logic out_en
);
   logic a_on, b_on;

   generate
      if (POL_A == OE_ACT_LOW) begin : g_a_lo
         assign a_on = ~oe_a;
      end else begin : g_a_hi
         assign a_on = oe_a;
      end

      if (POL_B == OE_IGNORE) begin : g_b_ign
         // either level enables
         assign b_on = oe_b | ~oe_b;
      end else if (POL_B == OE_ACT_LOW) begin : g_b_lo
         assign b_on = ~oe_b;
      end else begin : g_b_hi
         assign b_on = oe_b;
      end
   endgenerate

   assign chip_on = ~ce_n;
   assign out_en  = chip_on & a_on & b_on;
endmodule

// File: rtl/bwrom_lat_ctr.sv
module bwrom_lat_ctr #(
   parameter int LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic ready_next
);
   localparam int CW = $clog2(LAT + 1);

   logic [CW-1:0] cnt_q, cnt_n;

   always_comb begin
      if (restart)
         cnt_n = '0;
      else if (cnt_q == CW'(LAT))
         cnt_n = cnt_q;
      else
         cnt_n = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_n;
   end

   assign ready_next = (cnt_n == CW'(LAT));
endmodule

// File: rtl/bwrom_lane_steer.sv
module bwrom_lane_steer #(
   parameter int BW = 8
) (
   input  logic [2*BW-1:0] word,
   input  logic            word_mode,
   input  logic            lsb,
   output logic [2*BW-1:0] data
);
   localparam int DW = 2 * BW;

   assign data[BW-1:0]  = (word_mode | ~lsb) ? word[BW-1:0] : word[DW-1:BW];
   assign data[DW-1:BW] = word_mode ? word[DW-1:BW] : '0;
endmodule

// File: rtl/bwrom_port.sv
module bwrom_port
   import bwrom_pkg::*;
#(
   parameter int          AW       = 17,
   parameter int          BW       = 8,
   parameter int          ACC_LAT  = 3,
   parameter int          OE_LAT   = 1,
   parameter oe_pol_e     OE_A_POL = OE_ACT_LOW,
   parameter oe_pol_e     OE_B_POL = OE_ACT_HIGH,
   parameter logic [31:0] SEED     = 32'h0000_5A3C
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   addr,
   input  logic            a_lsb,
   input  logic            word_mode,
   input  logic            ce_n,
   input  logic            oe_a,
   input  logic            oe_b,
   output logic [2*BW-1:0] dout,
   output logic [2*BW-1:0] dout_oe,
   output logic            dvalid,
   output logic            standby
);
   localparam int DW = 2 * BW;
   localparam int KW = AW + 2;

   generate
      if (AW < 1 || AW > 31) begin : g_bad_aw
         $error("bwrom_port: AW out of range");
      end
      if (DW > 32) begin : g_bad_bw
         $error("bwrom_port: word wider than 32 bits");
      end
      if (ACC_LAT < 1 || OE_LAT < 1) begin : g_bad_lat
         $error("bwrom_port: latencies must be at least one cycle");
      end
      if (OE_A_POL == OE_IGNORE) begin : g_bad_pol
         $error("bwrom_port: first output enable cannot be ignored");
      end
   endgenerate

   logic chip_on, out_en;

   bwrom_en_dec #(.POL_A(OE_A_POL), .POL_B(OE_B_POL)) u_en (
      .ce_n    (ce_n),
      .oe_a    (oe_a),
      .oe_b    (oe_b),
      .chip_on (chip_on),
      .out_en  (out_en)
   );

   // access key: the byte select counts only in byte mode
   logic [KW-1:0] key, key_q;
   logic          chip_q, out_q, dvalid_q;
   logic [DW-1:0] dout_q;

   assign key = {word_mode, addr, a_lsb & ~word_mode};

   logic key_chg, restart_a, restart_o, ready_a, ready_o, valid_n;

   assign key_chg   = (key != key_q);
   assign restart_a = ~chip_on | ~chip_q | key_chg;
   assign restart_o = ~out_en | ~out_q;

   bwrom_lat_ctr #(.LAT(ACC_LAT)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart_a),
      .ready_next (ready_a)
   );

   bwrom_lat_ctr #(.LAT(OE_LAT)) u_oe (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart_o),
      .ready_next (ready_o)
   );

   assign valid_n = out_en & ready_a & ready_o;

   logic [DW-1:0] word, rd_data;
   assign word = DW'(rom_hash(32'(addr), SEED));

   bwrom_lane_steer #(.BW(BW)) u_steer (
      .word      (word),
      .word_mode (word_mode),
      .lsb       (a_lsb),
      .data      (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q    <= '0;
         chip_q   <= 1'b0;
         out_q    <= 1'b0;
         dvalid_q <= 1'b0;
         dout_q   <= '0;
      end else begin
         key_q    <= key;
         chip_q   <= chip_on;
         out_q    <= out_en;
         dvalid_q <= valid_n;
         if (valid_n)
            dout_q <= rd_data;
         else if (!(dvalid_q && key_chg))
            dout_q <= '0;
      end
   end

   // lane drive: low lane always, high lane only in word mode
   generate
      for (genvar i = 0; i < DW; i++) begin : g_lane
         if (i < BW) begin : g_lo
            assign dout_oe[i] = out_q;
         end else begin : g_hi
            assign dout_oe[i] = out_q & key_q[KW-1];
         end
      end
   endgenerate

   assign dout    = dout_q;
   assign dvalid  = dvalid_q;
   assign standby = ~chip_q;
endmodule

// File: rtl/bwrom_chk.sv
module bwrom_chk
   import bwrom_pkg::*;
#(
   parameter int      AW       = 17,
   parameter int      BW       = 8,
   parameter int      ACC_LAT  = 3,
   parameter int      OE_LAT   = 1,
   parameter oe_pol_e OE_A_POL = OE_ACT_LOW,
   parameter oe_pol_e OE_B_POL = OE_ACT_HIGH
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   addr,
   input logic            a_lsb,
   input logic            word_mode,
   input logic            ce_n,
   input logic            oe_a,
   input logic            oe_b,
   input logic [2*BW-1:0] dout,
   input logic [2*BW-1:0] dout_oe,
   input logic            dvalid,
   input logic            standby
);
   localparam int DW = 2 * BW;

   logic a_act, b_act, en_all;
   assign a_act  = (OE_A_POL == OE_ACT_HIGH) ? oe_a : ~oe_a;
   assign b_act  = (OE_B_POL == OE_IGNORE) ? (oe_b | ~oe_b)
                 : (OE_B_POL == OE_ACT_HIGH) ? oe_b : ~oe_b;
   assign en_all = ~ce_n & a_act & b_act;

   logic [AW+1:0] ck_key, ck_key_q;
   logic [15:0]   run_a, run_o;
   assign ck_key = {word_mode, addr, a_lsb & ~word_mode};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_key_q <= '0;
         run_a    <= '0;
         run_o    <= '0;
      end else begin
         ck_key_q <= ck_key;
         if (!ce_n && ck_key == ck_key_q)
            run_a <= (run_a == 16'hFFFF) ? run_a : run_a + 1'b1;
         else
            run_a <= '0;
         if (dout_oe[0])
            run_o <= (run_o == 16'hFFFF) ? run_o : run_o + 1'b1;
         else
            run_o <= '0;
      end
   end

   p_lane_on_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid |-> (dout_oe[BW-1:0] == {BW{1'b1}}));

   p_upper_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !word_mode |=> (dout_oe[DW-1:BW] == '0));

   p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (standby && dout_oe == '0 && !dvalid));

   p_oe_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !en_all) |=> (!standby && dout_oe == '0 && !dvalid));

   p_acc_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid |-> (run_a >= 16'(ACC_LAT)));

   p_oe_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid |-> (run_o >= 16'(OE_LAT)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && !ce_n && addr != $past(addr)) |=> (dout == $past(dout) && !dvalid));

   p_lsb_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && en_all && word_mode && $past(word_mode) && addr == $past(addr)) |=> dvalid);
endmodule

bind bwrom_port bwrom_chk #(
   .AW(AW), .BW(BW), .ACC_LAT(ACC_LAT), .OE_LAT(OE_LAT),
   .OE_A_POL(OE_A_POL), .OE_B_POL(OE_B_POL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .a_lsb(a_lsb), .word_mode(word_mode),
   .ce_n(ce_n), .oe_a(oe_a), .oe_b(oe_b), .dout(dout), .dout_oe(dout_oe),
   .dvalid(dvalid), .standby(standby)
);

// File: tb/tb_bwrom_port.sv
module tb_bwrom_port;
   import bwrom_pkg::*;

   localparam int          AW   = 17;
   localparam int          NLAT = 3;
   localparam int          MLAT = 1;
   localparam logic [31:0] SEED = 32'h0000_5A3C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic a_lsb = 1'b0, word_mode = 1'b1, ce_n = 1'b1, oe_a = 1'b1, oe_b = 1'b0;
   logic dc_oe_a = 1'b0;
   logic [15:0] dout, dout_oe, dc_dout, dc_oe;
   logic dvalid, standby, dc_valid, dc_standby;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   bwrom_port #(.AW(AW), .BW(8), .ACC_LAT(NLAT), .OE_LAT(MLAT),
                .OE_A_POL(OE_ACT_LOW), .OE_B_POL(OE_ACT_HIGH), .SEED(SEED)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .a_lsb(a_lsb), .word_mode(word_mode),
      .ce_n(ce_n), .oe_a(oe_a), .oe_b(oe_b), .dout(dout), .dout_oe(dout_oe),
      .dvalid(dvalid), .standby(standby));

   bwrom_port #(.AW(AW), .BW(8), .ACC_LAT(NLAT), .OE_LAT(MLAT),
                .OE_A_POL(OE_ACT_HIGH), .OE_B_POL(OE_IGNORE), .SEED(SEED)) dut_dc (
      .clk(clk), .rst_n(rst_n), .addr(addr), .a_lsb(a_lsb), .word_mode(word_mode),
      .ce_n(ce_n), .oe_a(dc_oe_a), .oe_b(oe_b), .dout(dc_dout), .dout_oe(dc_oe),
      .dvalid(dc_valid), .standby(dc_standby));

   function automatic logic [15:0] exp_word(input logic [AW-1:0] a);
      logic [31:0] m;
      m = 32'(a) * 32'h9E3779B1;
      m = m ^ (m >> 16) ^ SEED;
      return m[15:0];
   endfunction

   function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input logic wm, input logic ls);
      logic [15:0] w;
      w = exp_word(a);
      if (wm) return w;
      return ls ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic go(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung, expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] held;
      logic [AW-1:0] a1, a2;
      void'($urandom(32'd20240611));
      go(3);
      // R3: reset state
      chk(dout_oe == 16'h0 && !dvalid && standby, "R3 reset",
          {15'd0, standby, dout_oe}, {15'd0, 1'b1, 16'h0});
      rst_n = 1'b1;
      go(1);

      // R6 / R1: enable from standby, word read
      a1 = 17'h1_2345;
      addr = a1; word_mode = 1'b1; ce_n = 1'b0; oe_a = 1'b0; oe_b = 1'b1;
      go(1);
      chk(dout_oe == 16'hFFFF && !standby, "R1 drive on", {16'd0, dout_oe}, 32'h0000_FFFF);
      go(NLAT - 1);
      chk(!dvalid, "R6 not yet valid", {31'd0, dvalid}, 32'd0);
      go(1);
      chk(dvalid && dout == exp_word(a1), "R6 R9 valid word", {15'd0, dvalid, dout}, {15'd0, 1'b1, exp_word(a1)});

      // R8: hold one cycle after address change
      held = dout;
      a2 = 17'h0_0F0F;
      addr = a2;
      go(1);
      chk(dout == held && !dvalid, "R8 hold", {15'd0, dvalid, dout}, {16'd0, held});
      go(1);
      chk(dout == 16'h0 && !dvalid, "R8 gap", {15'd0, dvalid, dout}, 32'd0);
      go(NLAT - 1);
      chk(dvalid && dout == exp_word(a2), "R8 R6 new data", {15'd0, dvalid, dout}, {15'd0, 1'b1, exp_word(a2)});

      // R10: lsb ignored in word mode
      a_lsb = 1'b1;
      go(1);
      chk(dvalid && dout == exp_word(a2), "R10 lsb toggle", {15'd0, dvalid, dout}, {15'd0, 1'b1, exp_word(a2)});

      // R2: byte mode, both halves
      word_mode = 1'b0; a_lsb = 1'b0; addr = a1;
      go(NLAT + 1);
      chk(dvalid && dout == exp_read(a1, 1'b0, 1'b0), "R2 low byte", {16'd0, dout}, {16'd0, exp_read(a1, 1'b0, 1'b0)});
      chk(dout_oe == 16'h00FF, "R2 upper lane hiz", {16'd0, dout_oe}, 32'h0000_00FF);
      a_lsb = 1'b1;
      go(1);
      chk(!dvalid, "R2 R6 lsb restarts", {31'd0, dvalid}, 32'd0);
      go(NLAT);
      chk(dvalid && dout == exp_read(a1, 1'b0, 1'b1), "R2 high byte", {16'd0, dout}, {16'd0, exp_read(a1, 1'b0, 1'b1)});

      // R4 / R5: each output enable blocks
      oe_a = 1'b1;
      go(1);
      chk(dout_oe == 16'h0 && !dvalid && !standby, "R4 R5 oe_a inactive", {15'd0, standby, dout_oe}, 32'd0);
      oe_a = 1'b0; oe_b = 1'b0;
      go(1);
      chk(dout_oe == 16'h0 && !dvalid && !standby, "R4 R5 oe_b inactive", {15'd0, standby, dout_oe}, 32'd0);

      // R7: output-enable latency with settled address
      oe_b = 1'b1;
      go(1);
      chk(dout_oe == 16'h00FF && !dvalid, "R7 drive before valid", {15'd0, dvalid, dout_oe}, 32'h0000_00FF);
      go(MLAT);
      chk(dvalid && dout == exp_read(a1, 1'b0, 1'b1), "R7 valid after oe latency", {15'd0, dvalid, dout}, {15'd0, 1'b1, exp_read(a1, 1'b0, 1'b1)});

      // R3: chip disable overrides everything
      ce_n = 1'b1;
      go(1);
      chk(dout_oe == 16'h0 && !dvalid && standby, "R3 deselect", {15'd0, standby, dout_oe}, {15'd0, 1'b1, 16'h0});
      oe_a = 1'b1; oe_b = 1'b0; word_mode = 1'b1;
      go(2);
      chk(dout_oe == 16'h0 && !dvalid && standby, "R3 inputs ignored", {15'd0, standby, dout_oe}, {15'd0, 1'b1, 16'h0});

      // R5: ignore-setting instance, oe_b has no effect
      ce_n = 1'b0; oe_a = 1'b0; oe_b = 1'b0; dc_oe_a = 1'b1; addr = a2;
      go(NLAT + 1);
      chk(dc_valid && dc_oe == 16'hFFFF && dc_dout == exp_word(a2), "R5 ignore enable", {15'd0, dc_valid, dc_dout}, {15'd0, 1'b1, exp_word(a2)});
      chk(dout_oe == 16'h0, "R5 active-high oe_b blocks", {16'd0, dout_oe}, 32'd0);
      oe_b = 1'b1;
      go(1);
      chk(dc_valid && dc_dout == exp_word(a2), "R5 ignore after toggle", {15'd0, dc_valid, dc_dout}, {15'd0, 1'b1, exp_word(a2)});
      dc_oe_a = 1'b0;
      go(1);
      chk(dc_oe == 16'h0 && !dc_valid, "R5 active-high oe_a", {15'd0, dc_valid, dc_oe}, 32'd0);

      // random reads, R1 R2 R9
      for (int i = 0; i < 150; i++) begin
         addr = AW'($urandom);
         word_mode = 1'($urandom);
         a_lsb = 1'($urandom);
         go(NLAT + 1);
         chk(dvalid && dout == exp_read(addr, word_mode, a_lsb), "R9 random read",
             {15'd0, dvalid, dout}, {15'd0, 1'b1, exp_read(addr, word_mode, a_lsb)});
         chk(dout_oe == (word_mode ? 16'hFFFF : 16'h00FF), "R1 R2 random lanes",
             {16'd0, dout_oe}, {16'd0, (word_mode ? 16'hFFFF : 16'h00FF)});
      end

      summary();
      $finish;
   end
endmodule